// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a processor sequencer. It collects eleven interrupt sources and picks the most urgent one that may be serviced. It then presents that source's vector address together with a take strobe. The sources are three active-low external request pins, per-slot set pulses from on-chip peripherals (timer, host port read and write, two serial ports, powerdown) and two software interrupts. Each external pin can be set to edge or level sensitivity.

Software reaches the block through three write strobes that share one 16-bit data bus:
- a mask register, with one enable bit per maskable source;
- a control register, which holds pin sensitivity and the nesting mode;
- a write-only force/clear register, which sets or clears pending flags.

Two pulses turn servicing on and off globally. The sequencer answers a take with `ack`, which consumes the request and marks it in service. It signals the end of a handler with `rti`. The status stack stays outside the block. Because each source can be in service only once, and nesting only admits strictly higher levels, the in-service set is a bit vector. Its depth can never go past the twelve-level limit.

Slot indices used below, from lowest to highest priority, are:

| Slot | Source | Vector |
|------|--------|--------|
| 0 | timer | 0x0028 |
| 1 | IRQ0 / serial-1 receive | 0x0024 |
| 2 | IRQ1 / serial-1 transmit | 0x0020 |
| 3 | software 0 | 0x001C |
| 4 | software 1 | 0x0018 |
| 5 | serial-0 receive | 0x0014 |
| 6 | serial-0 transmit | 0x0010 |
| 7 | host read | 0x000C |
| 8 | host write | 0x0008 |
| 9 | IRQ2 | 0x0004 |
| 10 | powerdown | 0x002C |

Reset (vector 0x0000) is the block's own reset and is not a slot.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the mask, control, pending and in-service state are all zero, global servicing is enabled, and `take` is low with `vector` 0.
- R2: While `take` is high, `vector` is the address of the highest-numbered eligible slot per the slot table; while `take` is low, `vector` is 0.
- R3: Mask bit i (1 = enable) gates slot i for i = 0..9; slot 10 (powerdown) ignores the mask.
- R4: In the cycle after any mask write (`mask_we`), `take` is low.
- R5: `dis_ints` stops all servicing, powerdown included, from the next cycle; `ena_ints` restores it; if both pulse together, disable wins.
- R6: A control write stores `reg_wdata[2:0]` as the sensitivity of pins 0, 1 and 2 (1 = edge, 0 = level) and `reg_wdata[4]` as the mode (1 = nested, 0 = sequential).
- R7: Pins map to slots 1, 2 and 9. In level mode a pin requests its slot from the cycle after it is sampled low until the cycle after it is sampled high, and nothing is latched. In edge mode a sampled high-to-low change sets the slot's pending flag one cycle later. The flag stays set after the pin returns high.
- R8: A force/clear write sets pending flags from `reg_wdata[15:8]` and clears them from `reg_wdata[7:0]`. Bits 0..6 of each field map to slots 0..6 and bit 7 maps to slot 9. Clear beats force and every other set in the same cycle.
- R9: `ack` while `take` is high clears the winner's pending flag and marks it in service; `ack` without `take` has no effect.
- R10: In nested mode, a request is taken while another is in service only if its slot is strictly higher than the highest slot in service.
- R11: In sequential mode, nothing is taken while any slot is in service.
- R12: `rti` removes the highest slot from the in-service set.
- R13: A pulse on `hw_req[i]` sets the pending flag of slot i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 3 | External request pins 0..2, active low |
| hw_req | input | 11 | Per-slot set pulses from on-chip sources |
| reg_wdata | input | 16 | Register write data |
| mask_we | input | 1 | Write mask register from `reg_wdata[9:0]` |
| ctrl_we | input | 1 | Write control register |
| fc_we | input | 1 | Write force/clear register |
| ena_ints | input | 1 | Global enable pulse |
| dis_ints | input | 1 | Global disable pulse |
| ack | input | 1 | Sequencer accepts the offered interrupt |
| rti | input | 1 | Return from the current handler |
| take | output | 1 | An interrupt is offered |
| vector | output | 16 | Vector address of the offered interrupt |

## Verification
The assertions take for granted the following about the inputs:
- `irq_n` is already synchronous to `clk`;
- `rti` arrives only while a handler runs;
- `ack` and `rti` are not raised together.

The sequential-mode property also assumes the mode is not rewritten in the cycle of an acknowledge. The directed stimulus keeps to these rules. The randomized phase raises `rti` only when the bench model holds a slot in service. It keeps `ack` and `rti` exclusive, and it changes the pins only between clock edges.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  irq_n,
  input  logic [10:0] hw_req,
  input  logic [15:0] reg_wdata,
  input  logic        mask_we,
  input  logic        ctrl_we,
  input  logic        fc_we,
  input  logic        ena_ints,
  input  logic        dis_ints,
  input  logic        ack,
  input  logic        rti,
  output logic        take,
  output logic [15:0] vector
);
  localparam int NSRC = 11;
  localparam int PWD  = NSRC - 1;

  logic [9:0]      imask;
  logic [2:0]      sens;
  logic            nest, gie, mblk;
  logic [2:0]      pin_s, pin_d;
  logic [NSRC-1:0] pend, isr;
  logic [NSRC-1:0] pin_lvl, pin_fall, fc_set, fc_clr, elig, acc_bit, pop_bit;
  logic [3:0]      win, cur;
  logic            any, busy, acc;

  always_comb begin
    pin_lvl  = '0;
    pin_fall = '0;
    pin_lvl[1]  = ~pin_s[0] & ~sens[0];
    pin_lvl[2]  = ~pin_s[1] & ~sens[1];
    pin_lvl[9]  = ~pin_s[2] & ~sens[2];
    pin_fall[1] = pin_d[0] & ~pin_s[0] & sens[0];
    pin_fall[2] = pin_d[1] & ~pin_s[1] & sens[1];
    pin_fall[9] = pin_d[2] & ~pin_s[2] & sens[2];
  end

  always_comb begin
    fc_set = '0;
    fc_clr = '0;
    if (fc_we) begin
      fc_set[6:0] = reg_wdata[14:8];
      fc_set[9]   = reg_wdata[15];
      fc_clr[6:0] = reg_wdata[6:0];
      fc_clr[9]   = reg_wdata[7];
    end
  end

  assign elig = (pend | pin_lvl) & {1'b1, imask};

  always_comb begin
    win = '0; any = 1'b0; cur = '0; busy = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i]) begin win = 4'(i); any = 1'b1; end
      if (isr[i])  begin cur = 4'(i); busy = 1'b1; end
    end
  end

  assign take    = gie & ~mblk & any & (~busy | (nest & (win > cur)));
  assign vector  = !take ? 16'h0000 :
                   (win == 4'(PWD)) ? 16'h002C : 16'h0028 - {10'd0, win, 2'b00};
  assign acc     = take & ack;
  assign acc_bit = acc ? ({{(NSRC-1){1'b0}}, 1'b1} << win) : '0;
  assign pop_bit = (busy & rti) ? ({{(NSRC-1){1'b0}}, 1'b1} << cur) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask <= '0;
      sens  <= '0;
      nest  <= 1'b0;
      gie   <= 1'b1;
      mblk  <= 1'b0;
      pin_s <= '1;
      pin_d <= '1;
      pend  <= '0;
      isr   <= '0;
    end else begin
      pin_s <= irq_n;
      pin_d <= pin_s;
      mblk  <= mask_we;
      if (mask_we) imask <= reg_wdata[9:0];
      if (ctrl_we) begin
        sens <= reg_wdata[2:0];
        nest <= reg_wdata[4];
      end
      if (dis_ints)      gie <= 1'b0;
      else if (ena_ints) gie <= 1'b1;
      pend <= (pend | hw_req | pin_fall | fc_set) & ~fc_clr & ~acc_bit;
      isr  <= (isr & ~pop_bit) | acc_bit;
    end
  end

  assert_mask_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> !take);

  assert_global_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dis_ints |=> !take);

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_we && reg_wdata[7]) |=> !pend[9]);

  assert_ack_marks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ack) |=> (isr != '0));

  assert_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ack && !nest && !ctrl_we && !rti) |=> !take);

  assert_vector_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (vector[1:0] == 2'b00 && vector >= 16'h0004 && vector <= 16'h002C));
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] irq_n = 3'b111;
  logic [10:0] hw_req = '0;
  logic [15:0] reg_wdata = '0;
  logic mask_we = 0, ctrl_we = 0, fc_we = 0, ena_ints = 0, dis_ints = 0, ack = 0, rti = 0;
  logic take;
  logic [15:0] vector;

  irq_vector_ctrl dut (.clk(clk), .rst_n(rst_n), .irq_n(irq_n), .hw_req(hw_req),
    .reg_wdata(reg_wdata), .mask_we(mask_we), .ctrl_we(ctrl_we), .fc_we(fc_we),
    .ena_ints(ena_ints), .dis_ints(dis_ints), .ack(ack), .rti(rti),
    .take(take), .vector(vector));

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0, mismatched = 0;
  string cur_req = "R1";

  int vec_of [11] = '{40, 36, 32, 28, 24, 20, 16, 12, 8, 4, 44};
  int pin_slot [3] = '{1, 2, 9};
  int fc_slot [8] = '{0, 1, 2, 3, 4, 5, 6, 9};

  bit [10:0] m_pend, m_isr;
  bit [9:0] m_mask;
  bit [2:0] m_sens, m_p1, m_p2;
  bit m_nest, m_gie, m_mblk;

  function automatic bit m_lvl(int s);
    for (int p = 0; p < 3; p++)
      if (pin_slot[p] == s && !m_sens[p] && !m_p1[p]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int m_pick();
    for (int s = 10; s >= 0; s--) begin
      if ((m_pend[s] || m_lvl(s)) && (s == 10 || m_mask[s])) return s;
    end
    return -1;
  endfunction

  function automatic int m_top();
    for (int s = 10; s >= 0; s--) if (m_isr[s]) return s;
    return -1;
  endfunction

  function automatic bit m_take();
    int w, t;
    w = m_pick();
    t = m_top();
    if (w < 0 || !m_gie || m_mblk) return 1'b0;
    if (t < 0) return 1'b1;
    return m_nest && (w > t);
  endfunction

  task automatic model_reset();
    m_pend = '0; m_isr = '0; m_mask = '0; m_sens = '0; m_nest = 0;
    m_gie = 1; m_mblk = 0; m_p1 = '1; m_p2 = '1;
  endtask

  task automatic model_step();
    bit [10:0] np, ni;
    int w, t;
    bit tk;
    w = m_pick(); t = m_top(); tk = m_take();
    np = m_pend | hw_req;
    for (int p = 0; p < 3; p++)
      if (m_sens[p] && m_p2[p] && !m_p1[p]) np[pin_slot[p]] = 1'b1;
    if (fc_we) begin
      for (int b = 0; b < 8; b++) if (reg_wdata[8+b]) np[fc_slot[b]] = 1'b1;
      for (int b = 0; b < 8; b++) if (reg_wdata[b])   np[fc_slot[b]] = 1'b0;
    end
    ni = m_isr;
    if (rti && t >= 0) ni[t] = 1'b0;
    if (tk && ack) begin np[w] = 1'b0; ni[w] = 1'b1; end
    m_pend = np; m_isr = ni;
    if (dis_ints) m_gie = 0; else if (ena_ints) m_gie = 1;
    m_mblk = mask_we;
    if (mask_we) m_mask = reg_wdata[9:0];
    if (ctrl_we) begin m_sens = reg_wdata[2:0]; m_nest = reg_wdata[4]; end
    m_p2 = m_p1; m_p1 = irq_n;
  endtask

  task automatic compare();
    bit et;
    logic [15:0] ev;
    et = m_take();
    ev = et ? 16'(vec_of[m_pick()]) : 16'h0;
    compared++;
    if (take !== et || vector !== ev) begin
      mismatched++;
      $display("FAIL %s: take=%0b vector=%h expected take=%0b vector=%h", cur_req, take, vector, et, ev);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    hw_req = '0; mask_we = 0; ctrl_we = 0; fc_we = 0;
    ena_ints = 0; dis_ints = 0; ack = 0; rti = 0;
  endtask

  task automatic wr_mask(input logic [15:0] v); reg_wdata = v; mask_we = 1; tick(); endtask
  task automatic wr_ctrl(input logic [15:0] v); reg_wdata = v; ctrl_we = 1; tick(); endtask
  task automatic wr_fc(input logic [15:0] v);   reg_wdata = v; fc_we = 1;   tick(); endtask
  task automatic do_ack(); ack = 1; tick(); endtask
  task automatic do_rti(); rti = 1; tick(); endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; compare(); repeat (3) tick();

    cur_req = "R13"; hw_req[0] = 1; tick();
    cur_req = "R3";  repeat (2) tick();
    cur_req = "R4";  wr_mask(16'h03FF); tick();
    cur_req = "R9";  do_ack(); ack = 1; tick();
    cur_req = "R11"; hw_req = 11'b001_0010_0000; repeat (3) tick();
    cur_req = "R12"; do_rti();
    cur_req = "R2";  tick(); do_ack(); do_rti(); tick(); do_ack(); do_rti(); tick();

    cur_req = "R3";  wr_mask(16'h0000); hw_req[10] = 1; hw_req[8] = 1; tick(); tick();
    cur_req = "R5";  dis_ints = 1; tick(); repeat (2) tick();
    ena_ints = 1; tick(); tick();
    ena_ints = 1; dis_ints = 1; tick(); tick();
    ena_ints = 1; tick(); do_ack(); do_rti();

    cur_req = "R8";  wr_mask(16'h03FF); tick();
    wr_fc(16'h0800); tick(); wr_fc(16'h0008); tick();
    wr_fc(16'h8080); tick(); hw_req[9] = 1; reg_wdata = 16'h0080; fc_we = 1; tick(); tick();
    wr_fc(16'h00FF); tick();

    cur_req = "R6";  wr_ctrl(16'h0004); tick();
    cur_req = "R7";  irq_n[2] = 0; repeat (4) tick(); irq_n[2] = 1; repeat (2) tick();
    do_ack(); do_rti(); tick();
    irq_n[0] = 0; repeat (3) tick(); irq_n[0] = 1; repeat (3) tick();
    irq_n[1] = 0; repeat (2) tick(); do_ack(); tick(); irq_n[1] = 1; do_rti(); tick();

    cur_req = "R10"; wr_ctrl(16'h0010); hw_req[0] = 1; tick(); do_ack(); tick();
    hw_req[1] = 1; tick(); do_ack(); hw_req[0] = 1; repeat (2) tick();
    hw_req[10] = 1; tick(); do_ack(); tick();
    cur_req = "R12"; do_rti(); tick(); do_rti(); tick(); do_rti(); repeat (2) tick();
    do_ack(); do_rti(); tick();

    cur_req = "R2";
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      hw_req = 11'($urandom) & 11'($urandom) & 11'($urandom);
      if (r < 4)       begin reg_wdata = 16'($urandom); mask_we = 1; end
      else if (r < 7)  begin reg_wdata = 16'($urandom); ctrl_we = 1; end
      else if (r < 12) begin reg_wdata = 16'($urandom); fc_we = 1; end
      if (r >= 12 && r < 14) dis_ints = 1;
      if (r >= 14 && r < 20) ena_ints = 1;
      if (m_isr != 0 && r >= 20 && r < 35) rti = 1;
      else if (r >= 35 && r < 70) ack = 1;
      if (r >= 90) irq_n = 3'($urandom);
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule